// File: doc/BRIEF.md
# Two-Level Bus Arbiter with Parking and Stuck-Master Detection

This block decides which of seven masters owns a shared, PCI-style bus. Agent 0 is the on-chip master; agents 1 to 6 are the six masters outside the chip. Each agent has a request input and a grant output. The block watches the active-low frame and initiator-ready signals to tell when the bus is idle, and it moves the grant only then. Each agent is placed in one of two priority classes. A requesting high-class agent always beats a requesting low-class agent. Inside a class, agents take turns in round-robin order.

When nobody requests, the bus is parked. It stays with the last owner unless that owner has parking turned off, and in that case it goes to the on-chip master. A granted master that keeps requesting but never starts a transaction can be caught by a window counter. When the window expires, the master is marked broken and loses the grant. Its requests are then ignored until software clears its sticky flag.

Software reaches the block through a single register port. One select value addresses the control word. The other select value addresses the broken-flag status word, which is read back directly and cleared by writing ones.

Top module: `bus_arbiter`

## Requirements
- R1: At most one grant bit is high at any time. After reset the grant is parked on agent 0 (gnt = 7'b0000001) and every broken flag reads 0. Bit k of req and gnt belongs to agent k.
- R2: The grant changes only at a clock edge in whose preceding cycle frame_n and irdy_n were both high (bus idle).
- R3: Control bit 31 enables arbitration. While it is 0, only agent 0 can be granted, and requests from agents 1 to 6 get no grant.
- R4: Control bits 7+k hold the class of agent k (1 means high). At an idle re-arbitration, a requesting high-class agent is granted ahead of any requesting low-class agent.
- R5: Within a class, the next grant goes to the first requester after the last agent granted in that class, in cyclic index order.
- R6: When the bus is idle and no eligible request is pending, the grant stays on the current owner if that owner's park-disable bit (control bit 14+k) is 0.
- R7: If the current owner's park-disable bit is 1 and no eligible request is pending, the grant moves to agent 0.
- R8: A granted agent that keeps requesting and has not yet driven frame_n low keeps its grant, even against higher-class requests. Once it has started a transaction, the next idle cycle re-arbitrates.
- R9: Control bit 1 enables stuck-master detection, and control bits 6:3 hold the window W (0 means 16). If the owner keeps requesting with the bus idle and no frame for W clocks after the grant edge, its broken flag is set at the W-th edge and its grant is removed at the next edge.
- R10: A broken agent's requests are ignored. Its flag is sticky and is cleared only by writing 1 to status bit k (reg_sel = 1). A set and a clear in the same cycle leave the flag set.
- R11: With reg_sel = 0, reg_rdata returns the control word as last written. With reg_sel = 1, it returns the broken flags in bits 6:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 7 | Request per agent, bit 0 on-chip master |
| gnt | output | 7 | Grant per agent, one-hot or zero |
| frame_n | input | 1 | Active-low transaction-frame signal from the bus |
| irdy_n | input | 1 | Active-low initiator-ready signal from the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control word, 1 selects broken-flag status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |

## Verification
The bench builds the arbiter with the default of seven agents, so the class field and the park-disable field fill their full control-word ranges and every agent index can be driven. It runs the stuck-master window at value 3, which makes the flag edge and the grant-removal edge easy to pin down, and at value 0, which exercises the sixteen-clock wrap case. Starting from known pointer states, the test steps round-robin rotation, class precedence, the hold-before-frame rule and both parking outcomes in a fixed order, so every expected grant is exact.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned BDET_BIT = 1;
  localparam int unsigned WIN_LSB  = 3;
  localparam int unsigned WIN_W    = 4;
  localparam int unsigned PRIO_LSB = 7;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bus_arb_regs.sv
module bus_arb_regs
  import bus_arb_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [N-1:0]      brk_set,
  output logic [CTRL_W-1:0] rd_data,
  output logic              arb_en,
  output logic              bdet_en,
  output logic [WIN_W-1:0]  win,
  output logic [N-1:0]      prio,
  output logic [N-1:0]      park_dis,
  output logic [N-1:0]      broken
);
  localparam int unsigned PARK_LSB = PRIO_LSB + N;

  logic [CTRL_W-1:0] ctrl_q;
  logic [N-1:0]      brk_q;
  logic [N-1:0]      brk_clr;

  assign brk_clr = (wr_en && wr_sel == SEL_STATUS) ? wr_data[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      brk_q  <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_CTRL) ctrl_q <= wr_data;
      brk_q <= (brk_q & ~brk_clr) | brk_set;
    end
  end

  assign arb_en   = ctrl_q[EN_BIT];
  assign bdet_en  = ctrl_q[BDET_BIT];
  assign win      = ctrl_q[WIN_LSB +: WIN_W];
  assign prio     = ctrl_q[PRIO_LSB +: N];
  assign park_dis = ctrl_q[PARK_LSB +: N];
  assign broken   = brk_q;
  assign rd_data  = (wr_sel == SEL_STATUS) ? {{(CTRL_W-N){1'b0}}, brk_q} : ctrl_q;

  // R10: a cleared flag that was not re-set in the same cycle reads 0 afterwards
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STATUS) |=> ((brk_q & $past(wr_data[N-1:0] & ~brk_set)) == '0));
  // R10: flags are sticky without a clear
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_STATUS) |=> ((brk_q & $past(brk_q)) == $past(brk_q)));
endmodule

// File: rtl/bus_arb_rr.sv
module bus_arb_rr #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int off = 1; off <= int'(N); off++) begin
      int cand;
      cand = (int'(last) + off) % int'(N);
      if (!found && mask[cand]) begin
        found = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/bus_arb_wdog.sv
module bus_arb_wdog #(
  parameter int unsigned WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIN_W-1:0] win,
  input  logic             restart,
  input  logic             waiting,
  output logic             expire
);
  localparam int unsigned CNT_W = WIN_W + 1;
  localparam int unsigned FULL  = 1 << WIN_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;

  assign limit   = (win == '0) ? CNT_W'(FULL) : {1'b0, win};
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign expire  = en && !restart && waiting && (cnt_inc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !en)     cnt_q <= '0;
    else if (expire)             cnt_q <= '0;
    else if (waiting)            cnt_q <= cnt_inc;
  end

  // R9: a new grant always starts the window from zero
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R9: no expiry while detection is off
  p_no_expire_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int unsigned N_AGENTS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req,
  output logic [N_AGENTS-1:0] gnt,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic [CTRL_W-1:0]   reg_wdata,
  output logic [CTRL_W-1:0]   reg_rdata
);
  localparam int unsigned N     = N_AGENTS;
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             arb_en, bdet_en;
  logic [WIN_W-1:0] win;
  logic [N-1:0]     prio, park_dis, broken, brk_set;
  logic [N-1:0]     allowed, elig, hi_mask, lo_mask;
  logic [IDX_W-1:0] owner_q, owner_d, last_hi_q, last_lo_q, hi_idx, lo_idx;
  logic             hi_found, lo_found, upd_hi, upd_lo;
  logic             started_q, idle, hold, waiting, wd_expire, restart;

  bus_arb_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .brk_set(brk_set), .rd_data(reg_rdata), .arb_en(arb_en), .bdet_en(bdet_en),
    .win(win), .prio(prio), .park_dis(park_dis), .broken(broken)
  );

  assign idle    = frame_n && irdy_n;
  assign allowed = arb_en ? ~broken : (~broken & N'(1));
  assign elig    = req & allowed;
  assign hi_mask = elig & prio;
  assign lo_mask = elig & ~prio;

  bus_arb_rr #(.N(N), .IDX_W(IDX_W)) u_rr_hi (
    .mask(hi_mask), .last(last_hi_q), .found(hi_found), .idx(hi_idx)
  );
  bus_arb_rr #(.N(N), .IDX_W(IDX_W)) u_rr_lo (
    .mask(lo_mask), .last(last_lo_q), .found(lo_found), .idx(lo_idx)
  );

  assign hold    = req[owner_q] && allowed[owner_q] && !started_q;
  assign waiting = hold && idle;

  always_comb begin
    owner_d = owner_q;
    upd_hi  = 1'b0;
    upd_lo  = 1'b0;
    if (idle && !hold) begin
      if (hi_found) begin
        owner_d = hi_idx;
        upd_hi  = 1'b1;
      end else if (lo_found) begin
        owner_d = lo_idx;
        upd_lo  = 1'b1;
      end else if (!(allowed[owner_q] && !park_dis[owner_q])) begin
        owner_d = '0;
      end
    end
  end

  assign restart = (owner_d != owner_q);

  bus_arb_wdog #(.WIN_W(WIN_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(bdet_en), .win(win),
    .restart(restart), .waiting(waiting), .expire(wd_expire)
  );

  assign brk_set = wd_expire ? gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q   <= '0;
      started_q <= 1'b0;
      last_hi_q <= IDX_W'(N - 1);
      last_lo_q <= IDX_W'(N - 1);
    end else begin
      owner_q <= owner_d;
      if (restart)       started_q <= 1'b0;
      else if (!frame_n) started_q <= 1'b1;
      if (upd_hi) last_hi_q <= hi_idx;
      if (upd_lo) last_lo_q <= lo_idx;
    end
  end

  assign gnt = N'(1) << owner_q;

  // R1: never more than one grant
  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R2: grant frozen while the bus is busy
  p_busy_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(gnt));
  // R3: disabled arbitration grants no external agent
  p_disabled_internal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !arb_en) |=> (gnt[N-1:1] == '0));
  // R4: high class wins when not held
  p_high_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !hold && (hi_mask != '0)) |=> ((gnt & $past(prio)) != '0));
  // R9: an expiry marks the owner broken
  p_expire_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> ((broken & $past(gnt)) == $past(gnt)));

  generate
    for (genvar k = 1; k < int'(N); k++) begin : g_brk_chk
      // R10: a broken external agent loses the bus at the next idle edge
      p_broken_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && broken[k]) |=> !gnt[k]);
    end
  endgenerate
endmodule

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
  localparam int N = 7;
  localparam logic [31:0] EN   = 32'h8000_0000;
  localparam logic [31:0] BDET = 32'h0000_0002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  gnt;
  logic          frame_n = 1'b1;
  logic          irdy_n = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b1;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  bus_arbiter #(.N_AGENTS(N)) i_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .frame_n(frame_n), .irdy_n(irdy_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  task automatic txn(input logic [N-1:0] req_after);
    frame_n = 1'b0; req = req_after;
    step();
    frame_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset grant", 32'(gnt), 32'h1);
    chk("R1 reset flags", reg_rdata, 32'h0);
  endtask

  task automatic t_disabled();
    req = 7'b0000110;
    step(3);
    chk("R3 disabled keeps internal", 32'(gnt), 32'h1);
    req = '0;
    reg_sel = 1'b0;
    chk("R11 control readback", reg_rdata, 32'h0);
    reg_sel = 1'b1;
  endtask

  task automatic t_priority();
    wr(1'b0, EN | (32'h1 << 10));
    reg_sel = 1'b0;
    chk("R11 control readback", reg_rdata, EN | (32'h1 << 10));
    reg_sel = 1'b1;
    req = 7'b0001010;
    step();
    chk("R4 high class first", 32'(gnt), 32'h8);
    frame_n = 1'b0; req = 7'b0000010;
    step();
    chk("R2 busy no change", 32'(gnt), 32'h8);
    frame_n = 1'b1;
    step();
    chk("R4 low class after", 32'(gnt), 32'h2);
    txn('0);
    step(2);
    chk("R6 park on last", 32'(gnt), 32'h2);
  endtask

  task automatic t_park_off();
    wr(1'b0, EN | (32'h1 << 10) | (32'h1 << 15));
    step();
    chk("R7 park falls to internal", 32'(gnt), 32'h1);
  endtask

  task automatic t_round_robin();
    wr(1'b0, EN);
    req = 7'b0110100;
    step();
    chk("R5 rr first", 32'(gnt), 32'h04);
    txn(7'b0110100);
    chk("R5 rr second", 32'(gnt), 32'h10);
    txn(7'b0110100);
    chk("R5 rr third", 32'(gnt), 32'h20);
    txn(7'b0110100);
    chk("R5 rr wrap", 32'(gnt), 32'h04);
    txn('0);
  endtask

  task automatic t_hold();
    wr(1'b0, EN | (32'h1 << 11));
    req = 7'b0000010;
    step();
    chk("R8 low granted", 32'(gnt), 32'h02);
    req = 7'b0010010;
    step(4);
    chk("R8 hold before frame", 32'(gnt), 32'h02);
    txn(7'b0010000);
    chk("R8 release after start", 32'(gnt), 32'h10);
    txn('0);
  endtask

  task automatic t_broken_w3();
    wr(1'b0, EN | BDET | (32'd3 << 3));
    req = 7'b0100000;
    step();
    chk("R9 granted", 32'(gnt), 32'h20);
    step(2);
    chk("R9 no flag before window", reg_rdata, 32'h0);
    step();
    chk("R9 flag at window", reg_rdata, 32'h20);
    chk("R9 grant held on flag edge", 32'(gnt), 32'h20);
    step();
    chk("R9 grant removed", 32'(gnt), 32'h01);
    step(3);
    chk("R10 broken ignored", 32'(gnt), 32'h01);
    req = '0;
    step();
    chk("R10 flag sticky", reg_rdata, 32'h20);
    req = 7'b0100000;
    wr(1'b1, 32'h20);
    chk("R10 flag cleared", reg_rdata, 32'h0);
    step();
    chk("R10 regrant after clear", 32'(gnt), 32'h20);
    req = '0;
    step();
  endtask

  task automatic t_broken_w0();
    wr(1'b0, EN | BDET);
    req = 7'b1000000;
    step();
    chk("R9 granted w0", 32'(gnt), 32'h40);
    step(15);
    chk("R9 w0 no flag at 15", reg_rdata, 32'h0);
    step();
    chk("R9 w0 flag at 16", reg_rdata, 32'h40);
    req = '0;
    wr(1'b1, 32'h40);
    chk("R10 flag cleared w0", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_disabled();
    t_priority();
    t_park_off();
    t_round_robin();
    t_hold();
    t_broken_w3();
    t_broken_w0();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule